// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

The block is a watchdog timer that runs from its own low-speed clock, apart from the bus clock that software uses to program it. Software controls it by writing 16-bit magic values to a key register. One value opens the timing registers for writing. One value starts the countdown. One value restarts the countdown from the programmed reload value. A 3-bit prescaler code and a 12-bit reload value set the timeout. If software fails to refresh the watchdog in time, the block pulses a reset request for one watchdog-clock cycle and starts the next countdown.

Prescaler and reload writes are made in the bus domain and handed to the watchdog domain through a request/acknowledge handshake. A status register shows, for each of the two settings, whether a transfer is still in flight. Start and refresh commands cross as a synchronized level and a synchronized toggle. Once the watchdog is started, only the system reset `rst_n` stops it.

Top module: `kwdt_top`

## Requirements
- R1: After reset the prescaler reads 0, the reload reads 0xFFF, the status reads 0, and `wd_rst_req` stays low, because the watchdog is not counting.
- R2: The register map is: key at offset 0x0 (always reads 0), prescaler at 0x4 (code in bits 2:0), reload at 0x8 (value in bits 11:0), and status at 0xC (bit 0 = prescaler transfer pending, bit 1 = reload transfer pending). Unused read bits are 0.
- R3: The key is taken from bits 15:0 of a write to offset 0x0. The key 0x5555 opens the prescaler and reload registers for writing. A key write of any other value closes them again. While they are closed, writes to them leave the stored value unchanged.
- R4: An accepted write to the prescaler or the reload sets its status bit from the next bus cycle. The bit clears by itself once the watchdog domain has taken the value. A write to a register whose status bit is set is ignored.
- R5: The key 0xCCCC starts the watchdog. Before that, no reset request is issued, even when the refresh key is written.
- R6: Once the watchdog is running, reset requests come every (reload+1)×D watchdog-clock cycles. D is 4, 8, 16, 32, 64 or 128 for codes 0 to 5, and 256 for codes 6 and 7. New settings apply after their transfer has completed and a refresh has been issued.
- R7: Each reset request is high for exactly one watchdog-clock cycle, and the countdown then reloads by itself.
- R8: The key 0xAAAA restarts a running countdown from the reload value. If refreshes come more often than the timeout, no reset request occurs.
- R9: Once started, the watchdog cannot be stopped by any key write. Reset requests continue after other keys are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-interface clock |
| wd_clk | input | 1 | Low-speed watchdog clock |
| rst_n | input | 1 | Active-low asynchronous system reset for both domains |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wd_rst_req | output | 1 | One-cycle reset-request pulse in the watchdog domain |

## Verification
The assertions check the following on every cycle: a closed or busy register keeps its value when written, a pending flag rises after an accepted load, the start state is sticky in both domains, the reset pulse lasts one cycle, and the counter stays frozen until start. Some properties can only be shown by the bench's scenarios, because they need a long window or arithmetic across domains. These are the exact timeout length for each prescaler code and reload value, that settings apply after their transfer, that timely refreshes prevent any pulse, and that no key stops a running watchdog.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  parameter int PSC_W = 3;
  parameter int RLD_W = 12;
  parameter int DIV_W = 8;
  parameter int DW    = 32;
  parameter int AW    = 4;

  localparam logic [15:0] KEY_OPEN    = 16'h5555;
  localparam logic [15:0] KEY_START   = 16'hCCCC;
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;

  localparam logic [AW-1:0] OFS_KEY = 4'h0;
  localparam logic [AW-1:0] OFS_PSC = 4'h4;
  localparam logic [AW-1:0] OFS_RLD = 4'h8;
  localparam logic [AW-1:0] OFS_STS = 4'hC;

  // log2 of the division ratio selected by a prescaler code
  function automatic int div_log2(input logic [PSC_W-1:0] code);
    return (int'(code) >= 6) ? 8 : int'(code) + 2;
  endfunction

  // last prescaler count value before a tick
  function automatic logic [DIV_W-1:0] div_last(input logic [PSC_W-1:0] code);
    logic [DIV_W:0] t;
    t = (DIV_W+1)'(1) << div_log2(code);
    return DIV_W'(t - 1'b1);
  endfunction
endpackage

// File: rtl/kwdt_sync.sv
module kwdt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/kwdt_xfer.sv
module kwdt_xfer #(
  parameter int W = 12,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic [W-1:0] dout,
  output logic         upd
);
  logic req_t, ack_t, req_s, ack_s, req_d;

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) req_t <= 1'b0;
    else if (load && !busy) req_t <= ~req_t;
  end

  kwdt_sync #(.W(1)) u_ack_sync (.clk(clk_a), .rst_n(rst_n), .d(ack_t), .q(ack_s));
  assign busy = req_t ^ ack_s;

  kwdt_sync #(.W(1)) u_req_sync (.clk(clk_b), .rst_n(rst_n), .d(req_t), .q(req_s));
  assign upd = req_s ^ req_d;

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      req_d <= 1'b0;
      ack_t <= 1'b0;
      dout  <= INIT;
    end else begin
      req_d <= req_s;
      if (upd) begin
        dout  <= din;
        ack_t <= req_s;
      end
    end
  end

  // R4
  flag_rise_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    (load && !busy) |=> busy);
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             psc_busy,
  input  logic             rld_busy,
  output logic [PSC_W-1:0] psc_q,
  output logic [RLD_W-1:0] rld_q,
  output logic             psc_load,
  output logic             rld_load,
  output logic             en_q,
  output logic             rf_tgl
);
  logic wr, key_wr, open_q;
  logic [15:0] key;
  logic [DW-17:0] unused_hi;

  assign wr        = bus_en && bus_we;
  assign key       = bus_wdata[15:0];
  assign unused_hi = bus_wdata[DW-1:16];
  assign key_wr    = wr && (bus_addr == OFS_KEY);
  assign psc_load  = wr && (bus_addr == OFS_PSC) && open_q && !psc_busy;
  assign rld_load  = wr && (bus_addr == OFS_RLD) && open_q && !rld_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      en_q   <= 1'b0;
      rf_tgl <= 1'b0;
      psc_q  <= '0;
      rld_q  <= '1;
    end else begin
      if (key_wr) begin
        open_q <= (key == KEY_OPEN);
        if (key == KEY_START)   en_q   <= 1'b1;
        if (key == KEY_REFRESH) rf_tgl <= ~rf_tgl;
      end
      if (psc_load) psc_q <= bus_wdata[PSC_W-1:0];
      if (rld_load) rld_q <= bus_wdata[RLD_W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_PSC: bus_rdata = DW'(psc_q);
      OFS_RLD: bus_rdata = DW'(rld_q);
      OFS_STS: bus_rdata = DW'({rld_busy, psc_busy});
      default: bus_rdata = '0;
    endcase
  end

  // R3
  closed_psc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_PSC && !open_q) |=> $stable(psc_q));
  // R3
  closed_rld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_RLD && !open_q) |=> $stable(rld_q));
  // R4
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_RLD && rld_busy) |=> $stable(rld_q));
  // R9
  start_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_in,
  input  logic             rf_in,
  input  logic [PSC_W-1:0] psc,
  input  logic             psc_upd,
  input  logic [RLD_W-1:0] rld,
  output logic             rst_req
);
  logic en_s, rf_s, run, rf_d;
  logic start_ev, rf_ev, tick, expire;
  logic [DIV_W-1:0] pcnt;
  logic [RLD_W-1:0] cnt;

  kwdt_sync #(.W(2)) u_sync (.clk(clk), .rst_n(rst_n),
    .d({en_in, rf_in}), .q({en_s, rf_s}));

  assign start_ev = en_s && !run;
  assign rf_ev    = (rf_s ^ rf_d) && run;
  assign tick     = run && (pcnt == div_last(psc));
  assign expire   = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      rf_d    <= 1'b0;
      pcnt    <= '0;
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      run     <= en_s;
      rf_d    <= rf_s;
      rst_req <= expire && !start_ev && !rf_ev;
      if (start_ev || rf_ev || psc_upd || tick) pcnt <= '0;
      else if (run) pcnt <= pcnt + 1'b1;
      if (start_ev || rf_ev || expire) cnt <= rld;
      else if (tick) cnt <= cnt - 1'b1;
    end
  end

  // R7
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R9
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> ($stable(cnt) && !rst_req));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
(
  input  logic          bus_clk,
  input  logic          wd_clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wd_rst_req
);
  logic [PSC_W-1:0] psc_q, psc_w;
  logic [RLD_W-1:0] rld_q, rld_w;
  logic psc_load, rld_load, psc_busy, rld_busy, psc_upd, rld_upd;
  logic en_q, rf_tgl;
  logic unused_rld_upd;

  assign unused_rld_upd = rld_upd;

  kwdt_regs u_regs (
    .clk(bus_clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .psc_busy(psc_busy), .rld_busy(rld_busy), .psc_q(psc_q), .rld_q(rld_q),
    .psc_load(psc_load), .rld_load(rld_load), .en_q(en_q), .rf_tgl(rf_tgl));

  kwdt_xfer #(.W(PSC_W), .INIT('0)) u_psc_xfer (
    .clk_a(bus_clk), .clk_b(wd_clk), .rst_n(rst_n), .load(psc_load),
    .din(psc_q), .busy(psc_busy), .dout(psc_w), .upd(psc_upd));

  kwdt_xfer #(.W(RLD_W), .INIT('1)) u_rld_xfer (
    .clk_a(bus_clk), .clk_b(wd_clk), .rst_n(rst_n), .load(rld_load),
    .din(rld_q), .busy(rld_busy), .dout(rld_w), .upd(rld_upd));

  kwdt_core u_core (
    .clk(wd_clk), .rst_n(rst_n), .en_in(en_q), .rf_in(rf_tgl),
    .psc(psc_w), .psc_upd(psc_upd), .rld(rld_w), .rst_req(wd_rst_req));
endmodule

// File: tb/kwdt_top_test.sv
module kwdt_top_test;
  logic bus_clk = 0, wd_clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic wd_rst_req;
  int checks = 0, fails = 0, pulses = 0;

  always #2 bus_clk = ~bus_clk;
  always #14 wd_clk = ~wd_clk;

  kwdt_top uut (.bus_clk(bus_clk), .wd_clk(wd_clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_rst_req(wd_rst_req));

  always @(negedge wd_clk) if (wd_rst_req) pulses++;

  localparam int NV = 6;
  localparam int V_PSC [NV] = '{0, 1, 2, 5, 6, 7};
  localparam int V_RLD [NV] = '{3, 2, 0, 1, 0, 1};
  localparam int V_PER [NV] = '{16, 24, 16, 256, 256, 512};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge bus_clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge bus_clk); bus_addr = a; bus_we = 0;
    #1 v = int'(bus_rdata);
  endtask

  task automatic wait_idle();
    int s;
    for (int i = 0; i < 200; i++) begin
      rd(4'hC, s);
      if (s == 0) break;
    end
  endtask

  task automatic wd_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge wd_clk);
  endtask

  task automatic measure(output int per);
    per = 0;
    do @(negedge wd_clk); while (!wd_rst_req);
    do begin @(negedge wd_clk); per++; end while (!wd_rst_req);
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, p0, per;
    #20 rst_n = 1;
    // R1 reset state
    rd(4'h4, v); chk("R1 prescaler reset", v, 0);
    rd(4'h8, v); chk("R1 reload reset", v, 'hFFF);
    rd(4'hC, v); chk("R1 status reset", v, 0);
    // R2 key reads zero, unused offset zero
    wr(4'h0, 32'h1234);
    rd(4'h0, v); chk("R2 key reads zero", v, 0);
    // R3 closed writes ignored
    wr(4'h4, 5); rd(4'h4, v); chk("R3 closed prescaler", v, 0);
    wr(4'h8, 7); rd(4'h8, v); chk("R3 closed reload", v, 'hFFF);
    // R4 flag set, busy write ignored, flag clears
    wr(4'h0, 32'hFFFF5555);
    wr(4'h8, 5);
    rd(4'hC, v); chk("R4 reload flag set", v, 2);
    wr(4'h8, 7);
    wr(4'h4, 3);
    rd(4'hC, v); chk("R4 both flags", v, 3);
    wait_idle();
    rd(4'hC, v); chk("R4 flags clear", v, 0);
    rd(4'h8, v); chk("R4 busy write ignored", v, 5);
    rd(4'h4, v); chk("R2 prescaler field", v, 3);
    // R3 relock by another key
    wr(4'h0, 32'h0000);
    wr(4'h8, 9); rd(4'h8, v); chk("R3 relocked", v, 5);
    // R5 no pulse before start, refresh before start harmless
    wr(4'h0, 32'hAAAA);
    wd_wait(400);
    chk("R5 quiet before start", pulses, 0);
    // R5 start: expect pulse with period (5+1)*32
    wr(4'h0, 32'hCCCC);
    measure(per);
    measure(per); chk("R5 R6 period after start", per, 192);
    // R7 pulse width
    @(negedge wd_clk); chk("R7 one-cycle pulse", int'(wd_rst_req), 0);
    // R6 table
    for (int i = 0; i < NV; i++) begin
      wr(4'h0, 32'h5555);
      wr(4'h4, V_PSC[i]);
      wr(4'h8, V_RLD[i]);
      wait_idle();
      wr(4'h0, 32'hAAAA);
      measure(per);
      measure(per);
      chk($sformatf("R6 period code %0d reload %0d", V_PSC[i], V_RLD[i]), per, V_PER[i]);
    end
    // R8 refresh prevents pulse: code 2 reload 9 -> 160 cycles
    wr(4'h0, 32'h5555); wr(4'h4, 2); wr(4'h8, 9); wait_idle();
    wr(4'h0, 32'hAAAA);
    measure(per); chk("R8 setup period", per, 160);
    wr(4'h0, 32'hAAAA);
    p0 = pulses;
    for (int i = 0; i < 12; i++) begin
      wd_wait(60);
      wr(4'h0, 32'hAAAA);
    end
    chk("R8 refresh holds off", pulses - p0, 0);
    // R9 cannot stop
    wr(4'h0, 32'h0000);
    wr(4'h0, 32'h5555);
    wr(4'h0, 32'h1111);
    p0 = pulses;
    wd_wait(400);
    chk("R9 still running", int'(pulses - p0 >= 2), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule